// File: doc/BRIEF.md
# LED Driver Fault-Scan Sequencer

This block runs one complete open/short fault scan on a daisy chain of 8-channel constant-current LED sink drivers. The drivers have no dedicated command pins. They change mode when they see particular level patterns on their latch and output-enable lines, sampled over successive serial-clock cycles. A single start request causes the block to do the following in order:

- send the mode-entry pattern;
- shift a logic one into every channel, so that all outputs conduct during the test;
- pulse the latch;
- hold output enable low for a timed evaluation window;
- clock the per-channel fault flags back from the chain's serial output;
- send the mode-exit pattern.

The sequencer runs from the system clock. The serial clock is derived from it: every half period of the serial clock lasts `CLK_DIV` system clocks. All pin levels change only while the serial clock is low, and the serial input is sampled on the last system clock before each serial-clock falling edge. When the scan ends, the gathered flag vector is presented together with a one-cycle done pulse. The vector stays unchanged until the next accepted start.

Top module: `led_scan_seq`

## Requirements
- R1: Out of reset and while idle: serial clock low, latch low, output enable high (the pin is active low, so high means outputs off), serial data low, busy low, done low, fault vector all zeros.
- R2: After start, the first five serial-clock rising edges see output enable = 1,0,1,1,1 and latch = 0,0,0,1,0, in that order.
- R3: The next 8×CHAIN_LEN rising edges see serial data = 1, output enable = 1 and latch = 0.
- R4: After that load, exactly one latch pulse follows. It is 2×CLK_DIV system clocks wide, with the serial clock low and output enable high throughout, and it ends before output enable falls for evaluation.
- R5: Output enable then stays low for exactly EVAL_CYCLES system clocks, with the serial clock low and latch low, and output enable is never low while latch is high.
- R6: The next 8×CHAIN_LEN rising edges see output enable = 1 and latch = 0. The serial input is sampled just before each falling edge, and the first sampled bit ends in the fault vector's most significant bit.
- R7: The last five rising edges of a scan see output enable = 1,0,1,1,1 with latch held at 0, so a scan has 10 + 16×CHAIN_LEN rising edges in total.
- R8: Every serial-clock high phase lasts exactly CLK_DIV system clocks, and every low phase lasts at least CLK_DIV.
- R9: Busy is high from the cycle after an accepted start through the done pulse. Done is high for exactly one cycle, then busy falls. The fault vector is valid with done and holds until the next start.
- R10: A start request while busy is ignored: the scan in progress keeps its edge count and gives a single done pulse, and no second scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_start_i | input | 1 | Start request, one cycle, taken only when idle |
| drv_sdo_i | input | 1 | Serial data returned from the end of the driver chain |
| drv_sdi_o | output | 1 | Serial data to the first driver |
| drv_clk_o | output | 1 | Serial clock to the chain |
| drv_latch_o | output | 1 | Latch pin level |
| drv_oe_o | output | 1 | Output-enable pin level (low turns outputs on) |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle pulse at the end of a scan |
| fault_vec_o | output | 8×CHAIN_LEN | Fault flags, first returned bit in the MSB |

## Verification
A phase or slot counter that skips or repeats a value shows up at the pins within one serial-clock period. It appears as a wrong output-enable or latch level at the next rising edge, or as a wrong count of rising edges before the evaluation window. A wrong evaluation counter shows as an output-enable low interval of the wrong length, and that length is measured to the exact system clock. A capture register that shifts at the wrong moment or in the wrong direction is visible as soon as done rises, because distinct asymmetric fault words are returned and compared.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

   typedef enum logic [2:0] {
      SC_IDLE,
      SC_ENTRY,
      SC_LOAD,
      SC_LATCH,
      SC_EVAL,
      SC_READ,
      SC_RESUME,
      SC_DONE
   } scan_phase_e;

   // command patterns, bit i applies to serial-clock slot i
   localparam int          CMD_SLOTS    = 5;
   localparam logic [4:0]  CMD_OE_PAT   = 5'b11101;
   localparam logic [4:0]  CMD_LE_ENTRY = 5'b01000;

endpackage

// File: rtl/led_scan_tick.sv
module led_scan_tick #(
   parameter int HALF = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic half_end_o,
   output logic high_o
);

   generate
      if (HALF == 1) begin : g_direct
         assign half_end_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                        cnt_q <= '0;
            else if (!run_i)                    cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1))    cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
         end
         assign half_end_o = run_i && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         high_o <= 1'b0;
      else if (!run_i)     high_o <= 1'b0;
      else if (half_end_o) high_o <= ~high_o;
   end

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
   import led_scan_pkg::*;
#(
   parameter int BITS        = 16,
   parameter int EVAL_CYCLES = 128
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        start_i,
   input  logic        half_end_i,
   input  logic        high_i,
   output logic        run_o,
   output logic        clear_o,
   output logic        sample_o,
   output logic        sdi_o,
   output logic        sclk_o,
   output logic        latch_o,
   output logic        oe_o,
   output logic        busy_o,
   output logic        done_o
);

   localparam int MAXV = (EVAL_CYCLES > BITS) ? EVAL_CYCLES : BITS;
   localparam int CW   = $clog2(MAXV + CMD_SLOTS + 1);

   scan_phase_e   phase_q;
   logic [CW-1:0] cnt_q;
   logic          slot_end;

   assign slot_end = half_end_i && high_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= SC_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            SC_IDLE: if (start_i) begin
               phase_q <= SC_ENTRY;
               cnt_q   <= '0;
            end
            SC_ENTRY, SC_RESUME: if (slot_end) begin
               if (cnt_q == CW'(CMD_SLOTS - 1)) begin
                  phase_q <= (phase_q == SC_ENTRY) ? SC_LOAD : SC_DONE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SC_LOAD, SC_READ: if (slot_end) begin
               if (cnt_q == CW'(BITS - 1)) begin
                  phase_q <= (phase_q == SC_LOAD) ? SC_LATCH : SC_RESUME;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SC_LATCH: if (slot_end) begin
               phase_q <= SC_EVAL;
               cnt_q   <= '0;
            end
            SC_EVAL: begin
               if (cnt_q == CW'(EVAL_CYCLES - 1)) begin
                  phase_q <= SC_READ;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SC_DONE: phase_q <= SC_IDLE;
            default: phase_q <= SC_IDLE;
         endcase
      end
   end

   logic clocked;
   assign clocked  = (phase_q == SC_ENTRY) || (phase_q == SC_LOAD) ||
                     (phase_q == SC_READ)  || (phase_q == SC_RESUME);
   assign run_o    = clocked || (phase_q == SC_LATCH);
   assign clear_o  = (phase_q == SC_IDLE) && start_i;
   assign sample_o = (phase_q == SC_READ) && slot_end;
   assign sclk_o   = clocked && high_i;
   assign sdi_o    = (phase_q == SC_LOAD);
   assign busy_o   = (phase_q != SC_IDLE);
   assign done_o   = (phase_q == SC_DONE);

   always_comb begin
      oe_o    = 1'b1;
      latch_o = 1'b0;
      unique case (phase_q)
         SC_ENTRY: begin
            oe_o    = CMD_OE_PAT[cnt_q[2:0]];
            latch_o = CMD_LE_ENTRY[cnt_q[2:0]];
         end
         SC_RESUME: oe_o    = CMD_OE_PAT[cnt_q[2:0]];
         SC_LATCH:  latch_o = 1'b1;
         SC_EVAL:   oe_o    = 1'b0;
         default: ;
      endcase
   end

endmodule

// File: rtl/led_scan_capture.sv
module led_scan_capture #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] vec_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vec_o <= '0;
      else if (clear_i) vec_o <= '0;
      else if (shift_i) vec_o <= {vec_o[W-2:0], bit_i};
   end

endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq #(
   parameter int CHAIN_LEN   = 4,
   parameter int CLK_DIV     = 2,
   parameter int EVAL_CYCLES = 128,
   localparam int W          = 8 * CHAIN_LEN
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         scan_start_i,
   input  logic         drv_sdo_i,
   output logic         drv_sdi_o,
   output logic         drv_clk_o,
   output logic         drv_latch_o,
   output logic         drv_oe_o,
   output logic         scan_busy_o,
   output logic         scan_done_o,
   output logic [W-1:0] fault_vec_o
);

   generate
      if (CHAIN_LEN < 1) begin : g_bad_chain
         $error("CHAIN_LEN must be at least 1");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (EVAL_CYCLES < 2) begin : g_bad_eval
         $error("EVAL_CYCLES must be at least 2");
      end
   endgenerate

   logic run, half_end, high, clear, sample;

   led_scan_tick #(.HALF(CLK_DIV)) tick_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run),
      .half_end_o (half_end),
      .high_o     (high)
   );

   led_scan_ctrl #(.BITS(W), .EVAL_CYCLES(EVAL_CYCLES)) ctrl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (scan_start_i),
      .half_end_i (half_end),
      .high_i     (high),
      .run_o      (run),
      .clear_o    (clear),
      .sample_o   (sample),
      .sdi_o      (drv_sdi_o),
      .sclk_o     (drv_clk_o),
      .latch_o    (drv_latch_o),
      .oe_o       (drv_oe_o),
      .busy_o     (scan_busy_o),
      .done_o     (scan_done_o)
   );

   led_scan_capture #(.W(W)) cap_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .shift_i (sample),
      .bit_i   (drv_sdo_i),
      .vec_o   (fault_vec_o)
   );

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
   parameter int CLK_DIV = 2,
   parameter int W       = 16
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         scan_start_i,
   input logic         drv_sdi_o,
   input logic         drv_clk_o,
   input logic         drv_latch_o,
   input logic         drv_oe_o,
   input logic         scan_busy_o,
   input logic         scan_done_o,
   input logic [W-1:0] fault_vec_o
);

   localparam int RW = $clog2(CLK_DIV + 2);
   logic [RW-1:0] hi_run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hi_run <= '0;
      else if (drv_clk_o) hi_run <= hi_run + 1'b1;
      else                hi_run <= '0;
   end

   p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !scan_busy_o |-> (!drv_clk_o && drv_oe_o && !drv_latch_o && !drv_sdi_o));

   p_le_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_clk_o |-> $stable(drv_latch_o) && $stable(drv_oe_o));

   p_sdi_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_sdi_o |-> (drv_oe_o && !drv_latch_o));

   p_oe_le_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_oe_o |-> !drv_latch_o);

   p_clk_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(drv_clk_o) |-> (hi_run == RW'(CLK_DIV)));

   p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scan_done_o |=> (!scan_done_o && !scan_busy_o));

   p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!scan_busy_o && !scan_start_i) |=> $stable(fault_vec_o));

   p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (scan_busy_o && !scan_done_o && scan_start_i) |=> scan_busy_o);

endmodule

bind led_scan_seq led_scan_chk #(.CLK_DIV(CLK_DIV), .W(W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .scan_start_i (scan_start_i),
   .drv_sdi_o    (drv_sdi_o),
   .drv_clk_o    (drv_clk_o),
   .drv_latch_o  (drv_latch_o),
   .drv_oe_o     (drv_oe_o),
   .scan_busy_o  (scan_busy_o),
   .scan_done_o  (scan_done_o),
   .fault_vec_o  (fault_vec_o)
);

// File: tb/led_scan_seq_tb.sv
module led_scan_seq_tb_top;

   localparam int N    = 2;
   localparam int DIV  = 2;
   localparam int EVAL = 120;
   localparam int W    = 8 * N;
   localparam int BITS = W;
   localparam int TOTAL_RISES = 10 + 2 * BITS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sdo = 1'b0;
   logic sdi, sclk, le, oe, busy, done;
   logic [W-1:0] fvec;

   always #5 clk = ~clk;

   led_scan_seq #(.CHAIN_LEN(N), .CLK_DIV(DIV), .EVAL_CYCLES(EVAL)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .scan_start_i(start), .drv_sdo_i(sdo),
      .drv_sdi_o(sdi), .drv_clk_o(sclk), .drv_latch_o(le), .drv_oe_o(oe),
      .scan_busy_o(busy), .scan_done_o(done), .fault_vec_o(fvec));

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- pin monitor and chain model ----------------
   int          rc = 0;
   logic        oe_log [256];
   logic        le_log [256];
   logic        sdi_log[256];
   logic        p_sclk = 0, p_oe = 1, p_le = 0;
   int          hi_len = 0, lo_len = 0, width_bad = 0;
   int          le_len = 0, le_rc = 0, latch_cnt = 0, latch_pos = 0, latch_len = 0;
   bit          le_oe_low = 0, latch_oe_bad = 0;
   longint      cyc = 0, latch_end_t = 0, eval_start_t = 0;
   int          oe_len = 0, oe_rc = 0, eval_cnt = 0, eval_pos = 0, eval_len = 0;
   bit          oe_le_seen = 0, eval_le_bad = 0;
   int          done_cyc = 0;
   logic [W-1:0] fault_word = '0;
   logic [W-1:0] mdl = '0;

   always @(negedge clk) begin
      cyc++;
      if (done) done_cyc++;
      // serial clock edges
      if (sclk && !p_sclk) begin
         if (rc < 256) begin
            oe_log[rc] = oe; le_log[rc] = le; sdi_log[rc] = sdi;
         end
         rc++;
         if (lo_len < DIV) width_bad++;
         hi_len = 1;
         sdo = mdl[W-1];
         mdl = {mdl[W-2:0], 1'b0};
      end else if (sclk) begin
         hi_len++;
      end
      if (!sclk && p_sclk) begin
         if (hi_len != DIV) width_bad++;
         lo_len = 1;
      end else if (!sclk) begin
         lo_len++;
      end
      // latch pulses
      if (le && !p_le) begin
         le_rc = rc; le_len = 1; le_oe_low = !oe;
      end else if (le) begin
         le_len++; if (!oe) le_oe_low = 1;
      end
      if (!le && p_le && rc == le_rc) begin
         latch_cnt++; latch_pos = rc; latch_len = le_len;
         latch_oe_bad = le_oe_low; latch_end_t = cyc;
      end
      // output-enable low intervals
      if (!oe && p_oe) begin
         oe_rc = rc; oe_len = 1; oe_le_seen = le; eval_start_t = cyc;
      end else if (!oe) begin
         oe_len++; if (le) oe_le_seen = 1;
      end
      if (oe && !p_oe && rc == oe_rc) begin
         eval_cnt++; eval_pos = rc; eval_len = oe_len; eval_le_bad = oe_le_seen;
         mdl = fault_word;
      end
      p_sclk = sclk; p_oe = oe; p_le = le;
   end

   // ---------------- helpers ----------------
   task automatic wait_idle_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(!busy && !done, "R1 busy/done idle", {busy, done}, 0);
      chk(!sclk && !le && oe && !sdi, "R1 idle pins", {sclk, le, oe, sdi}, 4'b0010);
      chk(fvec == '0, "R1 fault vector cleared", fvec, 0);
   endtask

   task automatic t_scan(input logic [W-1:0] word, input bit poke_busy);
      int  b_rc, b_latch, b_eval, b_done, b_width;
      bit  ok;
      fault_word = word;
      b_rc = rc; b_latch = latch_cnt; b_eval = eval_cnt; b_done = done_cyc; b_width = width_bad;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy, "R9 busy after start", busy, 1);
      if (poke_busy) begin
         repeat (60) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      wait_idle_done(ok);
      chk(ok, "R9 done reached", ok, 1);
      chk(fvec == word, "R6 fault vector at done", fvec, word);
      // entry pattern
      for (int i = 0; i < 5; i++) begin
         chk(oe_log[b_rc+i] == ((5'b11101 >> i) & 1), "R2 entry oe",
             oe_log[b_rc+i], (5'b11101 >> i) & 1);
         chk(le_log[b_rc+i] == (i == 3), "R2 entry latch", le_log[b_rc+i], i == 3);
      end
      // all-ones load
      begin
         int bad = 0;
         for (int i = 5; i < 5 + BITS; i++)
            if (!(sdi_log[b_rc+i] && oe_log[b_rc+i] && !le_log[b_rc+i])) bad++;
         chk(bad == 0, "R3 load slots all ones", bad, 0);
      end
      // latch pulse
      chk(latch_cnt - b_latch == 1, "R4 latch pulse count", latch_cnt - b_latch, 1);
      chk(latch_pos - b_rc == 5 + BITS, "R4 latch after load", latch_pos - b_rc, 5 + BITS);
      chk(latch_len == 2 * DIV, "R4 latch width", latch_len, 2 * DIV);
      chk(!latch_oe_bad, "R4 oe high during latch", latch_oe_bad, 0);
      chk(latch_end_t <= eval_start_t, "R4 latch before eval", latch_end_t, eval_start_t);
      // evaluation window
      chk(eval_cnt - b_eval == 1, "R5 eval window count", eval_cnt - b_eval, 1);
      chk(eval_len == EVAL, "R5 eval window length", eval_len, EVAL);
      chk(eval_pos - b_rc == 5 + BITS, "R5 eval without clock", eval_pos - b_rc, 5 + BITS);
      chk(!eval_le_bad, "R5 latch low in eval", eval_le_bad, 0);
      // readback
      begin
         int bad = 0;
         for (int i = 5 + BITS; i < 5 + 2 * BITS; i++)
            if (!(oe_log[b_rc+i] && !le_log[b_rc+i])) bad++;
         chk(bad == 0, "R6 read slot pins", bad, 0);
      end
      // resume pattern
      for (int i = 0; i < 5; i++) begin
         int k = b_rc + 5 + 2 * BITS + i;
         chk(oe_log[k] == ((5'b11101 >> i) & 1), "R7 resume oe", oe_log[k], (5'b11101 >> i) & 1);
         chk(le_log[k] == 1'b0, "R7 resume latch low", le_log[k], 0);
      end
      @(negedge clk);
      chk(!busy && !done, "R9 idle after done", {busy, done}, 0);
      repeat (30) @(negedge clk);
      chk(rc - b_rc == TOTAL_RISES, "R7 R10 rising edge total", rc - b_rc, TOTAL_RISES);
      chk(done_cyc - b_done == 1, "R9 R10 single done cycle", done_cyc - b_done, 1);
      chk(!busy, "R10 no second scan", busy, 0);
      chk(fvec == word, "R9 vector held after done", fvec, word);
      chk(width_bad == b_width, "R8 clock phase widths", width_bad - b_width, 0);
   endtask

   // ---------------- main ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_scan(16'hA5C3, 1'b0);
      t_scan(16'h8000, 1'b1);
      t_scan(16'h0001, 1'b0);
      t_scan(16'h3C96, 1'b1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule